// File: doc/BRIEF.md
# Root-Port Legacy Interrupt Event Queue

This block collects legacy INTx assert and deassert events that a PCIe root port receives from the devices below it. It turns each event into a two-word record and stores it in a circular queue. Software reads and retires records through a small register window. The same window holds an interrupt decode register, an interrupt mask, a PHY status word and a root-port status/control word. One level-sensitive interrupt output goes high when a decoded cause is also enabled in the mask.

Events enter on a one-cycle strobe that carries a lane number and an assert/deassert level. Software reads the oldest record from two read registers. A write to the first read register pops that record. When the queue is full, an incoming event is dropped and a sticky overflow flag is set. The bridge-enable bit is a plain read/write control, and it is also driven out as a port for the address-window logic elsewhere in the chip.

The register port is synchronous. It has a 12-bit address and 32-bit data, and a read returns its data one cycle after the request.

Top module: `intx_event_queue`

## Requirements
- R1: After reset, `irqOut` and `bridgeEn` are 0. The decode, mask, root-port status/control and both read registers all read as 0.
- R2: An accepted event is stored as word 1 = bit 31 set (valid), the level in bit 29 and the 2-bit lane in bits 28:27, with all other bits 0. Word 2 of the record is 0.
- R3: The queue holds at most DEPTH-1 records. An event that arrives while it is full is dropped. Bit 19 of root-port status/control (address 0x148) then becomes 1 and stays 1 until reset.
- R4: Decode register bit 16 (address 0x138) is 1 whenever the queue holds a record. Writing 1 to bit 16 clears it only if the queue is empty after that cycle. If nothing clears it, it stays 1 after the queue drains.
- R5: `irqOut` is 1 exactly when decode bit 16 and mask bit 16 are both 1. A write to the mask register (0x13C) replaces all 32 bits, and the new value reads back.
- R6: Reading 0x158 or 0x15C returns word 1 or word 2 of the oldest record, or 0 when the queue is empty. A write to 0x158 removes the oldest record. That write has no effect when the queue is empty.
- R7: Bit 18 of root-port status/control reads 1 exactly when the queue is not empty. Writes do not change it.
- R8: Bit 0 of root-port status/control is read/write, and its value drives `bridgeEn`.
- R9: Bit 11 of the PHY status register (0x144) reflects the `linkUp` input. All other bits of that register read 0.
- R10: `regRdData` shows the value of the register addressed in the previous cycle when `regRdEn` was 1 then, and 0 otherwise. Unmapped addresses read 0.
- R11: When an event and a pop happen in the same cycle, both are applied. The full check and the empty check use the state from before that cycle.
- R12: Records are read out in the order their events arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtValid | input | 1 | Event strobe, one cycle per event |
| evtLane | input | 2 | Interrupt lane of the event (INTA..INTD as 0..3) |
| evtLevel | input | 1 | 1 = assert, 0 = deassert |
| linkUp | input | 1 | Static link-up indication |
| regRdEn | input | 1 | Register read request |
| regWrEn | input | 1 | Register write request |
| regAddr | input | 12 | Register byte address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data, one cycle after the request |
| irqOut | output | 1 | Level interrupt output |
| bridgeEn | output | 1 | Bridge-enable control bit |

## Verification
The bench builds the block with DEPTH = 4, so three records fill the queue. This makes it cheap to reach overflow, the wrap of both pointers, and a pop and an event in the same cycle against a full queue and against an empty one. The same runs at the default depth of 16 would need many more cycles but would test no new logic, because the pointer and flag logic depends on depth only through the wrap comparison.

// File: rtl/intq_pkg.sv
package intq_pkg;
  localparam int REG_AW = 12;
  localparam int REG_DW = 32;
  localparam int LANE_W = 2;

  localparam logic [REG_AW-1:0] ADDR_DECODE = 12'h138;
  localparam logic [REG_AW-1:0] ADDR_MASK   = 12'h13C;
  localparam logic [REG_AW-1:0] ADDR_PHY    = 12'h144;
  localparam logic [REG_AW-1:0] ADDR_RPCTL  = 12'h148;
  localparam logic [REG_AW-1:0] ADDR_WORD1  = 12'h158;
  localparam logic [REG_AW-1:0] ADDR_WORD2  = 12'h15C;

  localparam int BIT_INTX     = 16;
  localparam int BIT_LINK     = 11;
  localparam int BIT_BRIDGE   = 0;
  localparam int BIT_NONEMPTY = 18;
  localparam int BIT_OVERFLOW = 19;
  localparam int BIT_LANE     = 27;
  localparam int BIT_LEVEL    = 29;
  localparam int BIT_VALID    = 31;

  typedef struct packed {
    logic push;
    logic pop;
  } qStrobe_t;
endpackage

// File: rtl/intq_data.sv
module intq_data
  import intq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  qStrobe_t          strobe,
  input  logic [REG_DW-1:0] pushWord1,
  input  logic [REG_DW-1:0] pushWord2,
  output logic              empty,
  output logic              full,
  output logic              lastOne,
  output logic [REG_DW-1:0] headWord1,
  output logic [REG_DW-1:0] headWord2
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  logic [REG_DW-1:0] memWord1 [DEPTH];
  logic [REG_DW-1:0] memWord2 [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr, wrNext, rdNext;

  always_comb begin
    wrNext = (wrPtr == LAST_IDX) ? '0 : wrPtr + 1'b1;
    rdNext = (rdPtr == LAST_IDX) ? '0 : rdPtr + 1'b1;
    empty    = (wrPtr == rdPtr);
    full     = (wrNext == rdPtr);
    lastOne  = (rdNext == wrPtr);
    headWord1 = memWord1[rdPtr];
    headWord2 = memWord2[rdPtr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= wrNext;
      if (strobe.pop)  rdPtr <= rdNext;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.push) begin
      memWord1[wrPtr] <= pushWord1;
      memWord2[wrPtr] <= pushWord2;
    end
  end
endmodule

// File: rtl/intq_ctrl.sv
module intq_ctrl
  import intq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtValid,
  input  logic [LANE_W-1:0] evtLane,
  input  logic              evtLevel,
  input  logic              linkUp,
  input  logic              regRdEn,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [REG_DW-1:0] regWrData,
  input  logic              empty,
  input  logic              full,
  input  logic              lastOne,
  input  logic [REG_DW-1:0] headWord1,
  input  logic [REG_DW-1:0] headWord2,
  output qStrobe_t          strobe,
  output logic [REG_DW-1:0] pushWord1,
  output logic [REG_DW-1:0] pushWord2,
  output logic [REG_DW-1:0] regRdData,
  output logic              irqOut,
  output logic              bridgeEn,
  output logic              intxPend,
  output logic              ovfFlag
);
  logic [REG_DW-1:0] maskQ;
  logic [REG_DW-1:0] readVal;
  logic              bridgeQ;
  logic              clrIntx, nonEmptyAfter;

  always_comb begin
    strobe.push = evtValid && !full;
    strobe.pop  = regWrEn && (regAddr == ADDR_WORD1) && !empty;

    pushWord1 = '0;
    pushWord1[BIT_VALID] = 1'b1;
    pushWord1[BIT_LEVEL] = evtLevel;
    pushWord1[BIT_LANE +: LANE_W] = evtLane;
    pushWord2 = '0;

    clrIntx = regWrEn && (regAddr == ADDR_DECODE) && regWrData[BIT_INTX];
    nonEmptyAfter = strobe.push || (!empty && !(strobe.pop && lastOne));
  end

  always_comb begin
    readVal = '0;
    unique case (regAddr)
      ADDR_DECODE: readVal[BIT_INTX] = intxPend;
      ADDR_MASK:   readVal = maskQ;
      ADDR_PHY:    readVal[BIT_LINK] = linkUp;
      ADDR_RPCTL: begin
        readVal[BIT_BRIDGE]   = bridgeQ;
        readVal[BIT_NONEMPTY] = !empty;
        readVal[BIT_OVERFLOW] = ovfFlag;
      end
      ADDR_WORD1:  readVal = empty ? '0 : headWord1;
      ADDR_WORD2:  readVal = empty ? '0 : headWord2;
      default:     readVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ     <= '0;
      bridgeQ   <= 1'b0;
      intxPend  <= 1'b0;
      ovfFlag   <= 1'b0;
      regRdData <= '0;
    end else begin
      regRdData <= regRdEn ? readVal : '0;
      intxPend  <= (intxPend && !clrIntx) || nonEmptyAfter;
      if (evtValid && full) ovfFlag <= 1'b1;
      if (regWrEn && regAddr == ADDR_MASK)  maskQ   <= regWrData;
      if (regWrEn && regAddr == ADDR_RPCTL) bridgeQ <= regWrData[BIT_BRIDGE];
    end
  end

  assign irqOut   = intxPend && maskQ[BIT_INTX];
  assign bridgeEn = bridgeQ;
endmodule

// File: rtl/intx_event_queue.sv
module intx_event_queue
  import intq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtValid,
  input  logic [LANE_W-1:0] evtLane,
  input  logic              evtLevel,
  input  logic              linkUp,
  input  logic              regRdEn,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [REG_DW-1:0] regWrData,
  output logic [REG_DW-1:0] regRdData,
  output logic              irqOut,
  output logic              bridgeEn
);
  qStrobe_t          strobe;
  logic [REG_DW-1:0] pushWord1, pushWord2, headWord1, headWord2;
  logic              qEmpty, qFull, qLastOne, intxPend, ovfFlag;

  intq_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .evtValid(evtValid), .evtLane(evtLane), .evtLevel(evtLevel),
    .linkUp(linkUp),
    .regRdEn(regRdEn), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .empty(qEmpty), .full(qFull), .lastOne(qLastOne),
    .headWord1(headWord1), .headWord2(headWord2),
    .strobe(strobe), .pushWord1(pushWord1), .pushWord2(pushWord2),
    .regRdData(regRdData), .irqOut(irqOut), .bridgeEn(bridgeEn),
    .intxPend(intxPend), .ovfFlag(ovfFlag)
  );

  intq_data #(.DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .pushWord1(pushWord1), .pushWord2(pushWord2),
    .empty(qEmpty), .full(qFull), .lastOne(qLastOne),
    .headWord1(headWord1), .headWord2(headWord2)
  );
endmodule

// File: rtl/intq_checker.sv
module intq_checker
  import intq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              evtValid,
  input logic              regRdEn,
  input logic [REG_DW-1:0] regRdData,
  input logic              irqOut,
  input qStrobe_t          strobe,
  input logic [REG_DW-1:0] pushWord1,
  input logic [REG_DW-1:0] pushWord2,
  input logic              qEmpty,
  input logic              qFull,
  input logic              intxPend,
  input logic              ovfFlag
);
  assert_record_format_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> (pushWord1[BIT_VALID] && pushWord2 == '0));

  assert_drop_sets_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && qFull) |=> ovfFlag);

  assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag |=> ovfFlag);

  assert_no_push_when_full_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> !qFull);

  assert_no_pop_when_empty_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> !qEmpty);

  assert_pending_while_queued_R4: assert property (@(posedge clk) disable iff (!rstN)
    !qEmpty |-> intxPend);

  assert_irq_needs_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> intxPend);

  assert_idle_read_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(regRdEn) |-> (regRdData == '0));
endmodule

bind intx_event_queue intq_checker uChk (
  .clk(clk), .rstN(rstN), .evtValid(evtValid), .regRdEn(regRdEn),
  .regRdData(regRdData), .irqOut(irqOut), .strobe(strobe),
  .pushWord1(pushWord1), .pushWord2(pushWord2),
  .qEmpty(qEmpty), .qFull(qFull), .intxPend(intxPend), .ovfFlag(ovfFlag)
);

// File: tb/intx_event_queue_test.sv
module intx_event_queue_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH_T = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evtValid = 1'b0;
  logic [1:0]  evtLane = '0;
  logic        evtLevel = 1'b0;
  logic        linkUp = 1'b1;
  logic        regRdEn = 1'b0;
  logic        regWrEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqOut, bridgeEn;

  int compared = 0;
  int mismatched = 0;

  // reference state
  int unsigned mq[$];
  bit          mPend = 0, mBridge = 0, mOvf = 0;
  bit [31:0]   mMask = 0, expRd = 0;

  intx_event_queue #(.DEPTH(DEPTH_T)) uut (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtLane(evtLane),
    .evtLevel(evtLevel), .linkUp(linkUp), .regRdEn(regRdEn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqOut(irqOut), .bridgeEn(bridgeEn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit [31:0] modelRead(bit [11:0] a);
    bit [31:0] v = 0;
    case (a)
      12'h138: v[16] = mPend;
      12'h13C: v = mMask;
      12'h144: v[11] = linkUp;
      12'h148: begin v[0] = mBridge; v[18] = (mq.size() > 0); v[19] = mOvf; end
      12'h158: v = (mq.size() > 0) ? mq[0] : 0;
      12'h15C: v = 0;
      default: v = 0;
    endcase
    return v;
  endfunction

  task automatic modelStep();
    bit pushOk, popOk, clr;
    bit [31:0] rv;
    rv = modelRead(regAddr);
    pushOk = evtValid && (mq.size() < DEPTH_T - 1);
    popOk  = regWrEn && regAddr == 12'h158 && (mq.size() > 0);
    clr    = regWrEn && regAddr == 12'h138 && regWrData[16];
    if (evtValid && !pushOk) mOvf = 1;
    if (popOk) void'(mq.pop_front());
    if (pushOk) mq.push_back((32'h1 << 31) | (32'(evtLevel) << 29) | (32'(evtLane) << 27));
    mPend = (mPend && !clr) || (mq.size() > 0);
    if (regWrEn && regAddr == 12'h13C) mMask = regWrData;
    if (regWrEn && regAddr == 12'h148) mBridge = regWrData[0];
    expRd = regRdEn ? rv : 0;
  endtask

  task automatic cyc(string tag, bit ev = 0, bit [1:0] lane = 0, bit lvl = 0,
                     bit rd = 0, bit wr = 0, bit [11:0] a = 0, bit [31:0] d = 0);
    bit expIrq;
    evtValid = ev; evtLane = lane; evtLevel = lvl;
    regRdEn = rd; regWrEn = wr; regAddr = a; regWrData = d;
    modelStep();
    @(posedge clk);
    @(negedge clk);
    expIrq = mPend && mMask[16];
    compared++;
    if (regRdData !== expRd || irqOut !== expIrq || bridgeEn !== mBridge) begin
      mismatched++;
      $display("FAIL %s: rd=%h irq=%b br=%b expected rd=%h irq=%b br=%b",
               tag, regRdData, irqOut, bridgeEn, expRd, expIrq, mBridge);
    end
    evtValid = 0; regRdEn = 0; regWrEn = 0;
  endtask

  task automatic rdReg(string tag, bit [11:0] a);
    cyc(tag, 0, 0, 0, 1, 0, a, 0);
  endtask
  task automatic wrReg(string tag, bit [11:0] a, bit [31:0] d);
    cyc(tag, 0, 0, 0, 0, 1, a, d);
  endtask
  task automatic evt(string tag, bit [1:0] lane, bit lvl);
    cyc(tag, 1, lane, lvl);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rdReg("R1 reset decode", 12'h138);
    rdReg("R1 reset mask", 12'h13C);
    rdReg("R1 reset rpctl", 12'h148);
    rdReg("R1 reset word1", 12'h158);
    rdReg("R1 reset word2", 12'h15C);
    rdReg("R9 link up", 12'h144);
    // R2 encoding, R4 pending, R5 mask
    evt("R2 event lane2 assert", 2'd2, 1'b1);
    rdReg("R2 word1 format", 12'h158);
    rdReg("R2 word2 zero", 12'h15C);
    rdReg("R4 decode set", 12'h138);
    wrReg("R5 mask write", 12'h13C, 32'h0001_0000);
    rdReg("R5 mask readback", 12'h13C);
    // R3 fill + overflow, R7 status
    evt("R12 second event", 2'd1, 1'b0);
    evt("R12 third event", 2'd3, 1'b1);
    evt("R3 dropped when full", 2'd0, 1'b1);
    rdReg("R3 overflow and R7 nonempty", 12'h148);
    // R12 order, R6 pop
    rdReg("R12 head first", 12'h158);
    wrReg("R6 pop", 12'h158, 0);
    rdReg("R12 head second", 12'h158);
    wrReg("R6 pop", 12'h158, 0);
    rdReg("R12 head third", 12'h158);
    wrReg("R4 clear while queued", 12'h138, 32'h0001_0000);
    rdReg("R4 still set", 12'h138);
    wrReg("R6 pop last", 12'h158, 0);
    rdReg("R6 empty word1", 12'h158);
    wrReg("R6 pop on empty", 12'h158, 0);
    rdReg("R7 empty status", 12'h148);
    rdReg("R4 held after drain", 12'h138);
    wrReg("R4 w1c clear", 12'h138, 32'h0001_0000);
    rdReg("R5 irq low after clear", 12'h138);
    // R11 simultaneous, empty
    cyc("R11 push+pop on empty", 1, 2'd1, 1'b1, 0, 1, 12'h158, 0);
    rdReg("R11 push kept", 12'h158);
    evt("R11 fill", 2'd2, 1'b0);
    evt("R11 fill", 2'd3, 1'b0);
    cyc("R11 push+pop on full", 1, 2'd0, 1'b0, 0, 1, 12'h158, 0);
    rdReg("R11 head after", 12'h158);
    rdReg("R11 status", 12'h148);
    // R8 bridge, R7 write ignored
    wrReg("R8 bridge set", 12'h148, 32'hFFFF_FFFF);
    rdReg("R8 R7 rpctl readback", 12'h148);
    wrReg("R8 bridge clear", 12'h148, 32'h0);
    rdReg("R8 rpctl after clear", 12'h148);
    // R10 unmapped and idle
    rdReg("R10 unmapped 0x000", 12'h000);
    rdReg("R10 unmapped 0x140", 12'h140);
    cyc("R10 no read", 0, 0, 0, 0, 0, 12'h13C, 0);
    linkUp = 1'b0;
    rdReg("R9 link down", 12'h144);
    wrReg("R5 mask all", 12'h13C, 32'hFFFF_FFFF);
    rdReg("R5 mask readback all", 12'h13C);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule